// File: doc/BRIEF.md
# Iterative Integer Multiplier with HI/LO Result Registers

This block is the integer multiply engine of a small in-order core. It takes two 32-bit operands and forms their exact 64-bit product over several clock cycles. The upper half of the product goes into a dedicated HI register and the lower half into a dedicated LO register. A signed and an unsigned interpretation share one magnitude datapath. The low word is the same under both interpretations, so only the final sign fix-up of the upper half tells them apart.

The core issues a request with a start strobe, an operation code and two operands. It then watches busy and done. HI and LO are always readable, so move-from-HI and move-from-LO instructions can read them at any time. While a multiply is still running they return the previous result. The three-operand form also emits the low word on a writeback strobe that the core routes to a general register. At every commit the unit also reports whether the product fits in 32 bits under the chosen signedness.

Top module: `imul_hilo`

## Requirements
- R1: Every accepted multiply commits the exact 64-bit product of the two operands. The upper 32 bits go to `hi_o` and the lower 32 bits go to `lo_o`.
- R2: Op code 0 (signed to HI/LO) and op code 2 (signed three-operand) treat both operands as two's complement. This holds for 0x80000000: 0x80000000 × 0x80000000 gives HI=0x40000000 and LO=0x00000000, and 0xFFFFFFFE × 2 gives HI=0xFFFFFFFF and LO=0xFFFFFFFC.
- R3: Op code 1 (unsigned to HI/LO) treats every operand bit as magnitude. 0xFFFFFFFE × 2 gives HI=0x00000001 and LO=0xFFFFFFFC.
- R4: Op code 2 raises `wb_valid_o` for exactly the commit cycle, with `wb_data_o` equal to the committed low word. Op codes 0 and 1 never raise `wb_valid_o`. A start with op code 3 is ignored: `busy_o` stays low and HI/LO are unchanged.
- R5: After an accepted start, `busy_o` is high for 32 cycles for op code 1 and for 33 cycles for op codes 0 and 2. It then falls in the same cycle in which `done_o` pulses high for one cycle and the new HI/LO appear.
- R6: A start while `busy_o` is high is ignored, and the running operation completes with its own operands. `hi_o` and `lo_o` keep their previous values until the commit.
- R7: For signed ops, `fits_o` is 1 after a commit exactly when HI equals bit 31 of LO copied into all 32 bits.
- R8: For op code 1, `fits_o` is 1 after a commit exactly when HI is zero.
- R9: Reset drives `hi_o`, `lo_o`, `busy_o`, `done_o`, `fits_o`, `wb_valid_o` and `wb_data_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a multiply (taken only when idle) |
| op_i | input | 2 | 0 signed, 1 unsigned, 2 signed with writeback, 3 reserved |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when HI/LO commit |
| hi_o | output | 32 | HI register (move-from-HI read port) |
| lo_o | output | 32 | LO register (move-from-LO read port) |
| fits_o | output | 1 | Last product fits in 32 bits under its signedness |
| wb_valid_o | output | 1 | Register-write strobe for the three-operand form |
| wb_data_o | output | 32 | Low word for the destination register |

## Verification
The checker watches the handshake on every cycle. It checks that HI and LO stay frozen while busy is high, that done is a single pulse at the fall of busy, that a busy period lasts 32 or 33 cycles, and that the writeback strobe only comes with done. It also checks that a set fits flag always sits beside an upper word of all zeros or all ones. Only the bench scenarios can show that the products are correct, which signedness was used, that the flag is cleared when it should be, and that a start is ignored while busy or for the reserved op code. The bench compares those against products it computes itself from the operands.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [1:0] {
        OP_SMUL  = 2'd0,
        OP_UMUL  = 2'd1,
        OP_SMUL3 = 2'd2,
        OP_RSV   = 2'd3
    } imul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } imul_state_e;

endpackage

// File: rtl/imul_magnitude.sv
module imul_magnitude #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic             is_signed_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);
    always_comb begin
        neg_o = is_signed_i & val_i[WIDTH-1];
        mag_o = neg_o ? (~val_i + 1'b1) : val_i;
    end
endmodule

// File: rtl/imul_step.sv
module imul_step #(
    parameter int WIDTH = 32,
    localparam int PW = 2 * WIDTH
) (
    input  logic [PW-1:0] acc_i,
    input  logic [PW-1:0] mcand_i,
    input  logic          bit_i,
    output logic [PW-1:0] acc_o
);
    always_comb begin
        acc_o = bit_i ? (acc_i + mcand_i) : acc_i;
    end
endmodule

// File: rtl/imul_fit_check.sv
module imul_fit_check #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    input  logic             is_signed_i,
    output logic             fits_o
);
    always_comb begin
        if (is_signed_i) begin
            fits_o = (hi_i == {WIDTH{lo_i[WIDTH-1]}});
        end else begin
            fits_o = (hi_i == '0);
        end
    end
endmodule

// File: rtl/imul_hilo.sv
module imul_hilo
    import imul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o,
    output logic             fits_o,
    output logic             wb_valid_o,
    output logic [WIDTH-1:0] wb_data_o
);
    localparam int PW = 2 * WIDTH;
    localparam int CW = $clog2(WIDTH) + 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        imul_state_e     st;
        logic [CW-1:0]   cnt;
        logic [PW-1:0]   acc;
        logic [PW-1:0]   mcand;
        logic [WIDTH-1:0] mplier;
        logic            neg;
        logic            is_signed;
        logic            wb;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic            fits;
        logic            done;
        logic            wb_valid;
        logic [WIDTH-1:0] wb_data;
    } imul_regs_t;

    imul_regs_t s_d, s_q;

    // operand preparation: one magnitude unit per operand
    logic             req_signed;
    logic [WIDTH-1:0] opnd   [2];
    logic [WIDTH-1:0] mag    [2];
    logic             negbit [2];

    assign req_signed = (op_i != OP_UMUL);
    assign opnd[0] = a_i;
    assign opnd[1] = b_i;

    for (genvar g = 0; g < 2; g++) begin : g_mag
        imul_magnitude #(.WIDTH(WIDTH)) u_mag (
            .val_i       (opnd[g]),
            .is_signed_i (req_signed),
            .mag_o       (mag[g]),
            .neg_o       (negbit[g])
        );
    end

    // one shift-add step per cycle
    logic [PW-1:0] step_acc;
    imul_step #(.WIDTH(WIDTH)) u_step (
        .acc_i   (s_q.acc),
        .mcand_i (s_q.mcand),
        .bit_i   (s_q.mplier[0]),
        .acc_o   (step_acc)
    );

    // value committed this cycle, and its fit flag
    logic [PW-1:0] commit_val;
    logic          commit_fits;

    always_comb begin
        if (s_q.st == ST_FIX) begin
            commit_val = s_q.neg ? (~s_q.acc + 1'b1) : s_q.acc;
        end else begin
            commit_val = step_acc;
        end
    end

    imul_fit_check #(.WIDTH(WIDTH)) u_fit (
        .hi_i        (commit_val[PW-1:WIDTH]),
        .lo_i        (commit_val[WIDTH-1:0]),
        .is_signed_i (s_q.is_signed),
        .fits_o      (commit_fits)
    );

    always_comb begin
        logic do_commit;
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.wb_valid = 1'b0;
        do_commit    = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i && (op_i != OP_RSV)) begin
                    s_d.st        = ST_ITER;
                    s_d.cnt       = '0;
                    s_d.acc       = '0;
                    s_d.mcand     = {{WIDTH{1'b0}}, mag[0]};
                    s_d.mplier    = mag[1];
                    s_d.is_signed = req_signed;
                    s_d.neg       = req_signed & (negbit[0] ^ negbit[1]);
                    s_d.wb        = (op_i == OP_SMUL3);
                end
            end
            ST_ITER: begin
                s_d.acc    = step_acc;
                s_d.mcand  = s_q.mcand << 1;
                s_d.mplier = s_q.mplier >> 1;
                s_d.cnt    = s_q.cnt + 1'b1;
                if (s_q.cnt == LAST) begin
                    if (s_q.is_signed) begin
                        s_d.st = ST_FIX;
                    end else begin
                        do_commit = 1'b1;
                    end
                end
            end
            ST_FIX: begin
                do_commit = 1'b1;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase

        if (do_commit) begin
            s_d.st   = ST_IDLE;
            s_d.hi   = commit_val[PW-1:WIDTH];
            s_d.lo   = commit_val[WIDTH-1:0];
            s_d.fits = commit_fits;
            s_d.done = 1'b1;
            if (s_q.wb) begin
                s_d.wb_valid = 1'b1;
                s_d.wb_data  = commit_val[WIDTH-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = (s_q.st != ST_IDLE);
    assign done_o     = s_q.done;
    assign hi_o       = s_q.hi;
    assign lo_o       = s_q.lo;
    assign fits_o     = s_q.fits;
    assign wb_valid_o = s_q.wb_valid;
    assign wb_data_o  = s_q.wb_data;

endmodule

// File: rtl/imul_hilo_chk.sv
module imul_hilo_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o,
    input logic             fits_o,
    input logic             wb_valid_o
);
    logic [7:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy_o) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    // R6: results stay frozen during an operation
    assert_hold_hilo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($stable(hi_o) && $stable(lo_o)));

    // R5: done ends a busy period and lasts one cycle
    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: busy period length
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((busy_len == 8'd32) || (busy_len == 8'd33)));

    // R4: writeback strobe only with commit
    assert_wb_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    // R7 / R8: a fitting product has a sign-only upper word
    assert_fits_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fits_o |-> ((hi_o == '0) || (hi_o == '1)));

endmodule

bind imul_hilo imul_hilo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .hi_o       (hi_o),
    .lo_o       (lo_o),
    .fits_o     (fits_o),
    .wb_valid_o (wb_valid_o)
);

// File: tb/imul_hilo_bench.sv
module imul_hilo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o, done_o, fits_o, wb_valid_o;
    logic [31:0] hi_o, lo_o, wb_data_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    imul_hilo u_imul_hilo (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o), .fits_o(fits_o),
        .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [1:0] op,
                                             input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ea, eb;
        if (op == 2'd1) begin
            ea = {32'h0, a};
            eb = {32'h0, b};
        end else begin
            ea = {{32{a[31]}}, a};
            eb = {{32{b[31]}}, b};
        end
        return ea * eb;
    endfunction

    function automatic logic ref_fits(input logic [1:0] op, input logic [63:0] p);
        if (op == 2'd1) return (p[63:32] == 32'h0);
        return (p[63:32] == {32{p[31]}});
    endfunction

    task automatic do_op(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input bit poke);
        logic [63:0] exp_p;
        logic [31:0] old_hi, old_lo;
        int cycles;
        bit frozen;
        exp_p  = ref_prod(op, a, b);
        old_hi = hi_o;
        old_lo = lo_o;
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0; a_i = $urandom; b_i = $urandom;
        cycles = 0;
        frozen = 1'b1;
        while (!done_o && cycles < 100) begin
            if (busy_o) cycles++;
            if (hi_o !== old_hi || lo_o !== old_lo) frozen = 1'b0;
            if (poke && cycles == 5) begin
                start_i = 1'b1; op_i = 2'd1; a_i = ~a; b_i = b + 1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R5", "busy cycles", 64'(cycles), (op == 2'd1) ? 64'd32 : 64'd33);
        chk("R5", "busy low at done", {63'h0, busy_o}, 64'h0);
        chk("R6", "HI/LO held while busy", {63'h0, frozen}, 64'h1);
        chk(op == 2'd1 ? "R3" : "R2", "product", {hi_o, lo_o}, exp_p);
        chk(op == 2'd1 ? "R8" : "R7", "fits", {63'h0, fits_o},
            {63'h0, ref_fits(op, exp_p)});
        chk("R4", "wb_valid", {63'h0, wb_valid_o}, {63'h0, op == 2'd2});
        if (op == 2'd2) chk("R4", "wb_data", {32'h0, wb_data_o}, {32'h0, exp_p[31:0]});
        @(negedge clk);
        chk("R5", "done one cycle", {63'h0, done_o}, 64'h0);
        chk("R1", "HI/LO retained", {hi_o, lo_o}, exp_p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] h0, l0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", "reset outputs",
            {hi_o, lo_o}, 64'h0);
        chk("R9", "reset flags",
            {59'h0, busy_o, done_o, fits_o, wb_valid_o, |wb_data_o}, 64'h0);

        // directed corners
        do_op(2'd0, 32'hFFFFFFFE, 32'd2, 1'b0);   // R2
        do_op(2'd1, 32'hFFFFFFFE, 32'd2, 1'b0);   // R3
        do_op(2'd0, 32'h80000000, 32'h80000000, 1'b0);
        chk("R2", "most negative squared", {hi_o, lo_o}, 64'h40000000_00000000);
        do_op(2'd2, 32'h80000000, 32'hFFFFFFFF, 1'b1); // R6 poke
        do_op(2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        do_op(2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
        do_op(2'd0, 32'h0, 32'h12345678, 1'b0);
        do_op(2'd1, 32'h0000FFFF, 32'h00010001, 1'b0);

        // R4: reserved op ignored
        h0 = hi_o; l0 = lo_o;
        start_i = 1'b1; op_i = 2'd3; a_i = 32'd7; b_i = 32'd9;
        @(negedge clk);
        start_i = 1'b0;
        chk("R4", "reserved op busy", {63'h0, busy_o}, 64'h0);
        repeat (40) @(negedge clk);
        chk("R4", "reserved op HI/LO", {hi_o, lo_o}, {h0, l0});
        chk("R4", "reserved op done", {63'h0, done_o}, 64'h0);

        // constrained random
        for (int i = 0; i < 60; i++) begin
            logic [1:0] op;
            logic [31:0] a, b;
            op = 2'($urandom_range(0, 2));
            a = $urandom;
            b = $urandom;
            if ($urandom_range(0, 3) == 0) a = {32{a[0]}} ^ 32'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) b = 32'($urandom_range(0, 5));
            do_op(op, a, b, ($urandom_range(0, 4) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule